// File: doc/BRIEF.md
# DDR Bank Timing Enforcer

This block sits between a DDR command scheduler and the memory command pins. It keeps a timing record for each of four banks and, in every cycle, reports for the bank on `bank_i` which command types could be issued without breaking a minimum delay. The scheduler presents a decoded command together with the bank, the auto-precharge flag and the programmed burst length. A command is accepted in the same cycle only if its ready bit is high. If a command is presented while its ready bit is low, the block drops it and raises a one-cycle violation flag.

All delays are given in picoseconds as parameters. At elaboration each delay is converted to clock cycles as ceil(delay / clock period). The delay that follows a write with auto-precharge is formed from two terms: write recovery and precharge time are each rounded up to whole cycles on their own, and the two results are added. A bank that stays open longer than the maximum open time also raises the violation flag.

Top module: `ddr_bank_timer`

## Requirements
- R1: After reset every bank is closed, `violation_o` is low, ACT is ready, and RD and WR are not ready.
- R2: ACT to a bank needs that bank closed, at least tRP cycles since its precharge took effect, and at least tRC cycles since its previous ACT.
- R3: After an accepted ACT, no ACT to any bank is ready until tRRD cycles have passed.
- R4: RD and WR need the selected bank open and at least tRCD cycles since its ACT.
- R5: PRE to an open bank needs at least tRAS cycles since its ACT. An accepted PRE closes the bank in the next cycle.
- R6: After a WR without auto-precharge of B burst cycles, PRE to that bank waits B+tWR cycles, and RD to any bank waits B+tWTR cycles.
- R7: An accepted WR with auto-precharge (`ap_i`=1) closes its bank and blocks RD and WR to every bank for its B burst cycles. ACT to that bank becomes ready after B + ceil(tWR/tCK) + ceil(tRP/tCK) cycles.
- R8: RD with auto-precharge needs tRAS met as well as tRCD. It closes the bank, and ACT to that bank becomes ready after B+tRP cycles.
- R9: PRE with `ap_i`=1 targets all banks and is ready only when every open bank meets its PRE condition. PRE to a closed bank is ready and has no effect.
- R10: `bl_i` selects the burst: 0 is length 2 (1 cycle), 1 is length 4 (2 cycles), and 2 or 3 is length 8 (4 cycles).
- R11: A presented command whose ready bit is low is ignored: bank state and counters are unchanged, and `violation_o` is high in the next cycle only.
- R12: If a bank is still open and is not being closed in the cycle that reaches the maximum open time after its ACT, `violation_o` pulses high in the following cycle, once.
- R13: NOP is always ready. Column commands to an open bank may be issued in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE; other values act as NOP |
| bank_i | input | 2 | Target bank |
| ap_i | input | 1 | Auto-precharge on RD/WR; all-bank select on PRE |
| bl_i | input | 2 | Burst length code (see R10) |
| ready_o | output | 5 | Ready bit for each command code, for the bank on `bank_i` |
| bank_open_o | output | 4 | Open state of each bank |
| violation_o | output | 1 | One-cycle flag for an illegal command or an over-long open bank |

## Verification
The bench builds the block with a 8000 ps period, a 12000 ps write recovery, an 80000 ps row cycle and a 320000 ps maximum open time. These values give tRCD=3, tRP=3, tRRD=2, tRAS=6, tRC=10, tWR=2 and a 40-cycle open limit. Because tRC is then larger than tRAS+tRP, the row-cycle bound can be told apart from the precharge bound. The write recovery of 1.5 cycles makes rounding each term separately give a post-write delay of 5 cycles, where rounding the sum would give 4. The 40-cycle open limit keeps the expiry reachable in a short run.

// File: rtl/ddr_bt_pkg.sv
package ddr_bt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  localparam int NUM_CMD = 5;

  // round a delay up to whole clocks, never below one
  function automatic int ps2cyc(input int ps, input int tck);
    int c;
    c = (ps + tck - 1) / tck;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ddr_bt_bank.sv
module ddr_bt_bank #(
  parameter int CNT_W    = 6,
  parameter int OPEN_W   = 14,
  parameter int TRCD_C   = 3,
  parameter int TRAS_C   = 6,
  parameter int TRP_C    = 3,
  parameter int TRC_C    = 9,
  parameter int TWR_C    = 2,
  parameter int TDAL_C   = 5,
  parameter int OPEN_LIM = 16000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic       pre_i,
  input  logic       ap_i,
  input  logic [2:0] burst_i,
  output logic       open_o,
  output logic       act_ok_o,
  output logic       col_ok_o,
  output logic       tras_ok_o,
  output logic       pre_ok_o,
  output logic       expire_o
);

  localparam logic [CNT_W-1:0]  TRCD_L = CNT_W'(TRCD_C - 1);
  localparam logic [CNT_W-1:0]  TRAS_L = CNT_W'(TRAS_C - 1);
  localparam logic [CNT_W-1:0]  TRP_L  = CNT_W'(TRP_C - 1);
  localparam logic [CNT_W-1:0]  TRC_L  = CNT_W'(TRC_C - 1);
  localparam logic [CNT_W-1:0]  TWR_L  = CNT_W'(TWR_C - 1);
  localparam logic [CNT_W-1:0]  TDAL_L = CNT_W'(TDAL_C - 1);
  localparam logic [OPEN_W-1:0] AGE_MAX  = OPEN_W'(OPEN_LIM);
  localparam logic [OPEN_W-1:0] AGE_LAST = OPEN_W'(OPEN_LIM - 1);

  logic [CNT_W-1:0]  trcd_q, tras_q, trp_q, trc_q, twr_q;
  logic [CNT_W-1:0]  bst;
  logic [OPEN_W-1:0] age_q;
  logic              open_q;
  logic              close_req;

  function automatic logic [CNT_W-1:0] dn(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  assign bst       = CNT_W'(burst_i);
  assign close_req = open_q & (pre_i | ((rd_i | wr_i) & ap_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      trcd_q <= '0;
      tras_q <= '0;
      trp_q  <= '0;
      trc_q  <= '0;
      twr_q  <= '0;
    end else begin
      trcd_q <= dn(trcd_q);
      tras_q <= dn(tras_q);
      trp_q  <= dn(trp_q);
      trc_q  <= dn(trc_q);
      twr_q  <= dn(twr_q);
      if (act_i) begin
        open_q <= 1'b1;
        trcd_q <= TRCD_L;
        tras_q <= TRAS_L;
        trc_q  <= TRC_L;
      end else if (close_req) begin
        open_q <= 1'b0;
        if (pre_i)     trp_q <= TRP_L;
        else if (wr_i) trp_q <= bst + TDAL_L;
        else           trp_q <= bst + TRP_L;
      end else if (wr_i) begin
        twr_q <= bst + TWR_L;
      end
    end
  end

  // cycles open since activate, saturating at the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        age_q <= '0;
    else if (act_i)                     age_q <= '0;
    else if (open_q && age_q != AGE_MAX) age_q <= age_q + 1'b1;
  end

  assign open_o    = open_q;
  assign act_ok_o  = !open_q && trp_q == '0 && trc_q == '0;
  assign col_ok_o  = open_q && trcd_q == '0;
  assign tras_ok_o = tras_q == '0;
  assign pre_ok_o  = !open_q || (tras_q == '0 && twr_q == '0);
  assign expire_o  = open_q && age_q == AGE_LAST && !close_req;

endmodule

// File: rtl/ddr_bt_shared.sv
module ddr_bt_shared #(
  parameter int CNT_W  = 6,
  parameter int TRRD_C = 2,
  parameter int TWTR_C = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       wr_i,
  input  logic       ap_i,
  input  logic [2:0] burst_i,
  output logic       rrd_ok_o,
  output logic       wtr_ok_o,
  output logic       wap_ok_o
);

  localparam logic [CNT_W-1:0] TRRD_L = CNT_W'(TRRD_C - 1);
  localparam logic [CNT_W-1:0] TWTR_L = CNT_W'(TWTR_C - 1);

  logic [CNT_W-1:0] rrd_q, wtr_q, wap_q;
  logic [CNT_W-1:0] bst;

  assign bst = CNT_W'(burst_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrd_q <= '0;
      wtr_q <= '0;
      wap_q <= '0;
    end else begin
      rrd_q <= (rrd_q == '0) ? rrd_q : rrd_q - 1'b1;
      wtr_q <= (wtr_q == '0) ? wtr_q : wtr_q - 1'b1;
      wap_q <= (wap_q == '0) ? wap_q : wap_q - 1'b1;
      if (act_i)            rrd_q <= TRRD_L;
      if (wr_i && !ap_i)    wtr_q <= bst + TWTR_L;
      if (wr_i && ap_i)     wap_q <= bst - 1'b1;
    end
  end

  assign rrd_ok_o = rrd_q == '0;
  assign wtr_ok_o = wtr_q == '0;
  assign wap_ok_o = wap_q == '0;

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer
  import ddr_bt_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int TCK_PS      = 7500,
  parameter int TRCD_PS     = 20000,
  parameter int TRP_PS      = 20000,
  parameter int TRRD_PS     = 15000,
  parameter int TRC_PS      = 65000,
  parameter int TRAS_PS     = 45000,
  parameter int TRAS_MAX_PS = 120000000,
  parameter int TWR_PS      = 15000,
  parameter int TWTR_CK     = 1,
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 ap_i,
  input  logic [1:0]           bl_i,
  output logic [NUM_CMD-1:0]   ready_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 violation_o
);

  localparam int TRCD_C   = ps2cyc(TRCD_PS, TCK_PS);
  localparam int TRP_C    = ps2cyc(TRP_PS, TCK_PS);
  localparam int TRRD_C   = ps2cyc(TRRD_PS, TCK_PS);
  localparam int TRC_C    = ps2cyc(TRC_PS, TCK_PS);
  localparam int TRAS_C   = ps2cyc(TRAS_PS, TCK_PS);
  localparam int TWR_C    = ps2cyc(TWR_PS, TCK_PS);
  localparam int TDAL_C   = TWR_C + TRP_C;   // each term rounded on its own
  localparam int OPEN_LIM = ps2cyc(TRAS_MAX_PS, TCK_PS);
  localparam int MAX_LOAD = TRC_C + TRAS_C + TDAL_C + TRCD_C + TRRD_C + TWTR_CK + 8;
  localparam int CNT_W    = $clog2(MAX_LOAD + 1);
  localparam int OPEN_W   = $clog2(OPEN_LIM + 2);

  logic [2:0]           burst_c;
  logic [NUM_BANKS-1:0] act_ok, col_ok, tras_ok, pre_ok, expire, is_open;
  logic                 rrd_ok, wtr_ok, wap_ok;
  logic [NUM_CMD-1:0]   rdy;
  logic                 do_act, do_rd, do_wr, do_pre, illegal;
  logic                 viol_q;

  always_comb begin
    unique case (bl_i)
      2'd0:    burst_c = 3'd1;
      2'd1:    burst_c = 3'd2;
      default: burst_c = 3'd4;
    endcase
  end

  always_comb begin
    rdy          = '0;
    rdy[CMD_NOP] = 1'b1;
    rdy[CMD_ACT] = act_ok[bank_i] & rrd_ok;
    rdy[CMD_RD]  = col_ok[bank_i] & wtr_ok & wap_ok & (!ap_i | tras_ok[bank_i]);
    rdy[CMD_WR]  = col_ok[bank_i] & wap_ok & (!ap_i | tras_ok[bank_i]);
    rdy[CMD_PRE] = ap_i ? &pre_ok : pre_ok[bank_i];
  end

  assign do_act  = cmd_i == CMD_ACT && rdy[CMD_ACT];
  assign do_rd   = cmd_i == CMD_RD  && rdy[CMD_RD];
  assign do_wr   = cmd_i == CMD_WR  && rdy[CMD_WR];
  assign do_pre  = cmd_i == CMD_PRE && rdy[CMD_PRE];
  assign illegal = (cmd_i == CMD_ACT && !rdy[CMD_ACT]) ||
                   (cmd_i == CMD_RD  && !rdy[CMD_RD])  ||
                   (cmd_i == CMD_WR  && !rdy[CMD_WR])  ||
                   (cmd_i == CMD_PRE && !rdy[CMD_PRE]);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = bank_i == BANK_W'(g);
    ddr_bt_bank #(
      .CNT_W   (CNT_W),
      .OPEN_W  (OPEN_W),
      .TRCD_C  (TRCD_C),
      .TRAS_C  (TRAS_C),
      .TRP_C   (TRP_C),
      .TRC_C   (TRC_C),
      .TWR_C   (TWR_C),
      .TDAL_C  (TDAL_C),
      .OPEN_LIM(OPEN_LIM)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (do_act & sel),
      .rd_i     (do_rd & sel),
      .wr_i     (do_wr & sel),
      .pre_i    (do_pre & (ap_i | sel)),
      .ap_i     (ap_i),
      .burst_i  (burst_c),
      .open_o   (is_open[g]),
      .act_ok_o (act_ok[g]),
      .col_ok_o (col_ok[g]),
      .tras_ok_o(tras_ok[g]),
      .pre_ok_o (pre_ok[g]),
      .expire_o (expire[g])
    );
  end

  ddr_bt_shared #(
    .CNT_W (CNT_W),
    .TRRD_C(TRRD_C),
    .TWTR_C(TWTR_CK)
  ) u_shared (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (do_act),
    .wr_i    (do_wr),
    .ap_i    (ap_i),
    .burst_i (burst_c),
    .rrd_ok_o(rrd_ok),
    .wtr_ok_o(wtr_ok),
    .wap_ok_o(wap_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= illegal | (|expire);
  end

  assign ready_o     = rdy;
  assign bank_open_o = is_open;
  assign violation_o = viol_q;

endmodule

// File: rtl/ddr_bank_timer_chk.sv
module ddr_bank_timer_chk
  import ddr_bt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TCK_PS    = 7500,
  parameter int TRCD_PS   = 20000,
  parameter int TRRD_PS   = 15000,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           cmd_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic                 ap_i,
  input logic [1:0]           bl_i,
  input logic [NUM_CMD-1:0]   ready_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic                 violation_o
);

  localparam int TRCD_C = ps2cyc(TRCD_PS, TCK_PS);
  localparam int TRRD_C = ps2cyc(TRRD_PS, TCK_PS);

  logic [7:0] rdy_ext;
  logic       act_acc, pre_acc, wap_acc;

  assign rdy_ext = 8'(ready_o);
  assign act_acc = cmd_i == CMD_ACT && ready_o[CMD_ACT];
  assign pre_acc = cmd_i == CMD_PRE && ready_o[CMD_PRE];
  assign wap_acc = cmd_i == CMD_WR && ready_o[CMD_WR] && ap_i;

  // R11
  illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_NOP && cmd_i <= CMD_PRE && !rdy_ext[cmd_i]) |=> violation_o);

  // R2
  act_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_acc |=> bank_open_o[$past(bank_i)]);

  // R4
  rd_needs_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o[CMD_RD] |-> bank_open_o[bank_i]);

  // R2
  act_needs_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o[CMD_ACT] |-> !bank_open_o[bank_i]);

  // R5
  pre_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_acc && !ap_i) |=> !bank_open_o[$past(bank_i)]);

  // R9
  pre_all_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_acc && ap_i) |=> bank_open_o == '0);

  // R13
  nop_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o[CMD_NOP]);

  // R7
  wap_blocks_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wap_acc && bl_i != 2'd0) |=> (!ready_o[CMD_RD] && !ready_o[CMD_WR]));

  if (TRCD_C > 1) begin : g_rcd
    // R4
    rcd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_acc |=> !(ready_o[CMD_RD] && bank_i == $past(bank_i)));
  end

  if (TRRD_C > 1) begin : g_rrd
    // R3
    rrd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_acc |=> !ready_o[CMD_ACT]);
  end

endmodule

bind ddr_bank_timer ddr_bank_timer_chk #(
  .NUM_BANKS(NUM_BANKS),
  .TCK_PS   (TCK_PS),
  .TRCD_PS  (TRCD_PS),
  .TRRD_PS  (TRRD_PS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_i      (cmd_i),
  .bank_i     (bank_i),
  .ap_i       (ap_i),
  .bl_i       (bl_i),
  .ready_o    (ready_o),
  .bank_open_o(bank_open_o),
  .violation_o(violation_o)
);

// File: tb/ddr_bank_timer_bench.sv
`timescale 1ns/1ps
module ddr_bank_timer_bench;
  import ddr_bt_pkg::*;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic       ap = 1'b0;
  logic [1:0] bl = 2'd0;
  logic [4:0] ready;
  logic [3:0] bank_open;
  logic       viol;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;

  always #4 clk_i = ~clk_i;

  ddr_bank_timer #(
    .TCK_PS     (8000),
    .TWR_PS     (12000),
    .TRC_PS     (80000),
    .TRAS_MAX_PS(320000)
  ) u_ddr_bank_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .bank_i     (bank),
    .ap_i       (ap),
    .bl_i       (bl),
    .ready_o    (ready),
    .bank_open_o(bank_open),
    .violation_o(viol)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk_i);
    cmd = CMD_NOP;
    #1;
  endtask

  task automatic nxtn(input int n);
    for (int i = 0; i < n; i++) nxt();
  endtask

  task automatic probe(input int ty, input int b, input bit a, input int exp, input string req);
    bank = 2'(b);
    ap   = a;
    #1;
    chk(req, int'(ready[ty]), exp);
  endtask

  task automatic drive(input logic [2:0] c, input int b, input bit a);
    @(negedge clk_i);
    cmd  = c;
    bank = 2'(b);
    ap   = a;
    #1;
  endtask

  task automatic issue(input logic [2:0] c, input int b, input bit a, input string req);
    drive(c, b, a);
    chk(req, int'(ready[c]), 1);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cmd = CMD_NOP; bank = 2'd0; ap = 1'b0; bl = 2'd0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 banks closed", int'(bank_open), 0);
    chk("R1 violation low", int'(viol), 0);
    probe(CMD_ACT, 0, 0, 1, "R1 act ready");
    probe(CMD_RD, 0, 0, 0, "R1 rd blocked");
    probe(CMD_WR, 2, 0, 0, "R1 wr blocked");
    probe(CMD_NOP, 1, 0, 1, "R13 nop ready");
  endtask

  task automatic t_rcd_rrd();
    do_reset();
    issue(CMD_ACT, 0, 0, "R2 act");
    nxt();
    probe(CMD_ACT, 1, 0, 0, "R3 rrd c1");
    probe(CMD_RD, 0, 0, 0, "R4 rcd c1");
    nxt();
    probe(CMD_ACT, 1, 0, 1, "R3 rrd c2");
    probe(CMD_RD, 0, 0, 0, "R4 rcd c2");
    nxt();
    probe(CMD_RD, 0, 0, 1, "R4 rd c3");
    probe(CMD_WR, 0, 0, 1, "R4 wr c3");
    issue(CMD_RD, 0, 0, "R13 first rd");
    issue(CMD_RD, 0, 0, "R13 back to back rd");
  endtask

  task automatic t_ras_rc();
    do_reset();
    issue(CMD_ACT, 0, 0, "R2 act");
    nxtn(5);
    probe(CMD_PRE, 0, 0, 0, "R5 ras c5");
    issue(CMD_PRE, 0, 0, "R5 pre c6");
    nxt();
    chk("R5 closed", int'(bank_open[0]), 0);
    nxtn(2);
    probe(CMD_ACT, 0, 0, 0, "R2 rc c9");
    nxt();
    probe(CMD_ACT, 0, 0, 1, "R2 rc c10");
  endtask

  task automatic t_rp();
    do_reset();
    issue(CMD_ACT, 0, 0, "R2 act");
    nxtn(11);
    issue(CMD_PRE, 0, 0, "R5 pre c12");
    nxtn(2);
    probe(CMD_ACT, 0, 0, 0, "R2 rp c14");
    nxt();
    probe(CMD_ACT, 0, 0, 1, "R2 rp c15");
  endtask

  task automatic t_wr();
    do_reset();
    bl = 2'd1;
    issue(CMD_ACT, 0, 0, "R2 act");
    nxtn(5);
    issue(CMD_WR, 0, 0, "R4 wr");
    nxt();
    probe(CMD_RD, 0, 0, 0, "R6 wtr w1");
    probe(CMD_PRE, 0, 0, 0, "R6 twr w1");
    nxt();
    probe(CMD_RD, 0, 0, 0, "R10 bl4 wtr w2");
    nxt();
    probe(CMD_RD, 0, 0, 1, "R6 wtr w3");
    probe(CMD_PRE, 0, 0, 0, "R6 twr w3");
    nxt();
    probe(CMD_PRE, 0, 0, 1, "R6 twr w4");
  endtask

  task automatic t_wr_ap();
    do_reset();
    bl = 2'd2;
    issue(CMD_ACT, 0, 0, "R2 act b0");
    nxt();
    issue(CMD_ACT, 1, 0, "R3 act b1");
    nxtn(5);
    issue(CMD_WR, 1, 1, "R7 wr ap");
    nxt();
    chk("R7 bank closed", int'(bank_open[1]), 0);
    probe(CMD_RD, 0, 0, 0, "R7 rd blocked w1");
    probe(CMD_WR, 0, 0, 0, "R7 wr blocked w1");
    nxtn(2);
    probe(CMD_RD, 0, 0, 0, "R10 bl8 window w3");
    nxt();
    probe(CMD_RD, 0, 0, 1, "R7 rd released w4");
    nxtn(4);
    probe(CMD_ACT, 1, 0, 0, "R7 dal w8");
    nxt();
    probe(CMD_ACT, 1, 0, 1, "R7 dal w9");
  endtask

  task automatic t_rd_ap();
    do_reset();
    bl = 2'd0;
    issue(CMD_ACT, 3, 0, "R2 act");
    nxtn(4);
    probe(CMD_RD, 3, 1, 0, "R8 ras for ap");
    probe(CMD_RD, 3, 0, 1, "R8 plain rd ok");
    nxtn(3);
    issue(CMD_RD, 3, 1, "R8 rd ap");
    nxt();
    chk("R8 bank closed", int'(bank_open[3]), 0);
    nxtn(2);
    probe(CMD_ACT, 3, 0, 0, "R8 rp w3");
    nxt();
    probe(CMD_ACT, 3, 0, 1, "R8 rp w4");
  endtask

  task automatic t_pre_all();
    do_reset();
    issue(CMD_ACT, 0, 0, "R2 act b0");
    nxt();
    issue(CMD_ACT, 2, 0, "R3 act b2");
    nxtn(4);
    probe(CMD_PRE, 1, 1, 0, "R9 all blocked");
    probe(CMD_PRE, 0, 0, 1, "R9 single ok");
    probe(CMD_PRE, 1, 0, 1, "R9 closed bank ok");
    nxt();
    issue(CMD_PRE, 1, 1, "R9 pre all");
    nxt();
    chk("R9 all closed", int'(bank_open), 0);
  endtask

  task automatic t_illegal();
    do_reset();
    drive(CMD_RD, 0, 0);
    nxt();
    chk("R11 flag", int'(viol), 1);
    chk("R11 bank stays closed", int'(bank_open), 0);
    issue(CMD_ACT, 0, 0, "R2 act");
    chk("R11 one shot", int'(viol), 0);
    drive(CMD_ACT, 0, 0);
    nxt();
    chk("R11 flag act", int'(viol), 1);
    chk("R11 bank stays open", int'(bank_open[0]), 1);
    nxt();
    probe(CMD_RD, 0, 0, 1, "R11 rcd not restarted");
  endtask

  task automatic t_open_max();
    do_reset();
    issue(CMD_ACT, 1, 0, "R2 act");
    nxtn(40);
    chk("R12 no flag at limit", int'(viol), 0);
    nxt();
    chk("R12 flag", int'(viol), 1);
    nxt();
    chk("R12 single pulse", int'(viol), 0);
    do_reset();
    issue(CMD_ACT, 1, 0, "R2 act");
    nxtn(39);
    issue(CMD_PRE, 1, 0, "R12 pre at limit");
    nxt();
    chk("R12 closed in time", int'(viol), 0);
  endtask

  initial begin
    t_reset();
    t_rcd_rrd();
    t_ras_rc();
    t_rp();
    t_wr();
    t_wr_ap();
    t_rd_ap();
    t_pre_all();
    t_illegal();
    t_open_max();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule